// File: doc/BRIEF.md
# Top-of-Memory Reserved Region Controller

This controller sits on the single write port of a 1 MB byte-addressed memory shared by sixteen cores. It owns two small windows at the very top of the 20-bit address space: 16 per-core debug vector longs in the highest 64 bytes, and 16 per-core event longs in the 64 bytes just below them. When a write lands on an event long, the owning core gets a one-cycle event pulse. After cold reset, a built-in sequencer fills every debug vector with a return-from-debug instruction word before any external write is accepted.

While a program image is being loaded, writes that carry the download flag cannot reach the vector window. The boot values therefore survive a download. Ordinary writes still reach the vector window, so user code can install its own vectors later. A separate combinational decoder sorts an instruction fetch address into one of three execution classes: core-register, lookup-table or shared-memory.

Top module: `shmem_resv_ctrl`

## Requirements
- R1: While reset is asserted, mem_we is 0, core_event is all zeros, and both req_ready and boot_done are 0.
- R2: After reset is released, the block issues exactly 16 memory writes, one per cycle with no gap. Write i goes to byte address $FFFC0 + 4*i (i = 0..15, ascending), with data equal to the RET_WORD parameter and mem_be = 4'b1111.
- R3: boot_done goes to 1 in the cycle after the 16th boot write and stays 1 until the next reset. req_ready is 0 until boot_done is 1. Any request presented before then produces no write and no event.
- R4: After boot, a request with req_valid=1 and req_download=0 appears on mem_we/mem_addr/mem_wdata/mem_be in the same cycle, unchanged. This also holds for addresses in $FFFC0..$FFFFF.
- R5: After boot, a request with req_download=1 whose address lies in $FFFC0..$FFFFF produces mem_we=0. A download write anywhere else passes through as in R4.
- R6: An accepted write with at least one mem_be bit set, to byte address $FFF80 + 4*n (any address inside that long), raises core_event[n] for exactly the next cycle. Back-to-back writes give back-to-back pulses.
- R7: An accepted write with req_be = 0, or to an address outside $FFF80..$FFFBF, raises no event.
- R8: exec_region is 0 (core-register) for fetch_addr $00000..$001FF, 1 (lookup-table) for $00200..$003FF and 2 (shared-memory) for $00400..$FFFFF. It responds combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_addr | input | 20 | Byte address of the request |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| req_download | input | 1 | Request belongs to a program-image download |
| req_ready | output | 1 | Requests are accepted (low during boot fill) |
| mem_we | output | 1 | Write strobe to memory |
| mem_addr | output | 20 | Byte address to memory |
| mem_wdata | output | 32 | Data to memory |
| mem_be | output | 4 | Byte enables to memory |
| core_event | output | 16 | One-cycle event pulse per core |
| boot_done | output | 1 | Vector fill has completed |
| fetch_addr | input | 20 | Fetch address to classify |
| exec_region | output | 2 | Execution class of fetch_addr |

## Verification
Two functions can compete in one cycle. Requests presented during the boot fill must lose to the sequencer, and download masking must coincide with the event snoop. The bench drives event-window writes during the fill, then download writes to vector and event longs. Every cycle, a behavioural model predicts the memory port and the pulse vector, which must match exactly: writes during the fill are absent, vector writes in download mode are suppressed, and event writes still pulse.

// File: rtl/shmem_resv_pkg.sv
package shmem_resv_pkg;

  typedef enum logic [1:0] {
    XR_CORE   = 2'd0,
    XR_TABLE  = 2'd1,
    XR_SHARED = 2'd2
  } xregion_e;

  // inclusive window test on zero-extended byte addresses
  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // long index inside a window starting at base
  function automatic logic [31:0] long_index(input logic [31:0] a,
                                             input logic [31:0] base);
    return (a - base) >> 2;
  endfunction

  function automatic xregion_e classify(input logic [31:0] a,
                                        input logic [31:0] core_lim,
                                        input logic [31:0] tbl_lim);
    if (a < core_lim)     return XR_CORE;
    else if (a < tbl_lim) return XR_TABLE;
    else                  return XR_SHARED;
  endfunction

endpackage

// File: rtl/resv_boot_fill.sv
module resv_boot_fill #(
  parameter int          ADDR_W   = 20,
  parameter int          N_CORES  = 16,
  parameter int unsigned VEC_BASE = 32'hFFFC0,
  parameter logic [31:0] RET_WORD = 32'hFCB0_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              fill_we,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [31:0]       fill_data,
  output logic              fill_done
);
  localparam int CNT_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_CORES - 1);

  logic [CNT_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= '0;
      fill_done <= 1'b0;
    end else if (!fill_done) begin
      idx <= idx + 1'b1;
      if (idx == LAST) fill_done <= 1'b1;
    end
  end

  always_comb begin
    fill_we   = rst_n && !fill_done;
    fill_addr = ADDR_W'(VEC_BASE) + ADDR_W'({idx, 2'b00});
    fill_data = RET_WORD;
  end

  // boot writes step upward one long per cycle
  assert_fill_ascend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && $past(fill_we)) |-> (fill_addr == $past(fill_addr) + ADDR_W'(4)));

  assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> fill_done);

endmodule

// File: rtl/resv_event_snoop.sv
module resv_event_snoop
  import shmem_resv_pkg::*;
#(
  parameter int          ADDR_W   = 20,
  parameter int          N_CORES  = 16,
  parameter int unsigned EVT_BASE = 32'hFFF80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_fire,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [3:0]         wr_be,
  output logic [N_CORES-1:0] evt
);
  localparam int unsigned EVT_TOP = EVT_BASE + 4 * N_CORES - 1;

  logic               evt_hit;
  logic [31:0]        evt_idx;
  logic [N_CORES-1:0] evt_sel;

  always_comb begin
    evt_hit = wr_fire && (wr_be != 4'b0000) && in_window(32'(wr_addr), EVT_BASE, EVT_TOP);
    evt_idx = long_index(32'(wr_addr), EVT_BASE);
  end

  for (genvar n = 0; n < N_CORES; n++) begin : g_core
    assign evt_sel[n] = evt_hit && (evt_idx == 32'(n));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= '0;
    else        evt <= evt_sel;
  end

  assert_one_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evt));

  assert_evt_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_sel) |=> ((|evt) && $past(wr_be != 4'b0000)));

endmodule

// File: rtl/resv_exec_decode.sv
module resv_exec_decode
  import shmem_resv_pkg::*;
#(
  parameter int          ADDR_W   = 20,
  parameter int unsigned CORE_LIM = 32'h200,
  parameter int unsigned TBL_LIM  = 32'h400
) (
  input  logic [ADDR_W-1:0] fetch_addr,
  output xregion_e          region
);
  always_comb region = classify(32'(fetch_addr), CORE_LIM, TBL_LIM);
endmodule

// File: rtl/shmem_resv_ctrl.sv
module shmem_resv_ctrl
  import shmem_resv_pkg::*;
#(
  parameter int          ADDR_W   = 20,
  parameter int          N_CORES  = 16,
  parameter logic [31:0] RET_WORD = 32'hFCB0_0001,
  parameter int unsigned CORE_LIM = 32'h200,
  parameter int unsigned TBL_LIM  = 32'h400
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  input  logic [3:0]         req_be,
  input  logic               req_download,
  output logic               req_ready,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [31:0]        mem_wdata,
  output logic [3:0]         mem_be,
  output logic [N_CORES-1:0] core_event,
  output logic               boot_done,
  input  logic [ADDR_W-1:0]  fetch_addr,
  output logic [1:0]         exec_region
);
  localparam int unsigned SPAN     = 4 * N_CORES;
  localparam int unsigned VEC_BASE = (32'd1 << ADDR_W) - SPAN;
  localparam int unsigned VEC_TOP  = VEC_BASE + SPAN - 1;
  localparam int unsigned EVT_BASE = VEC_BASE - SPAN;

  logic              fill_we;
  logic [ADDR_W-1:0] fill_addr;
  logic [31:0]       fill_data;
  logic              wr_fire;
  logic              vec_hit;
  logic              dl_block;
  xregion_e          region;

  resv_boot_fill #(
    .ADDR_W(ADDR_W), .N_CORES(N_CORES), .VEC_BASE(VEC_BASE), .RET_WORD(RET_WORD)
  ) u_fill (
    .clk(clk), .rst_n(rst_n), .fill_we(fill_we), .fill_addr(fill_addr),
    .fill_data(fill_data), .fill_done(boot_done)
  );

  always_comb begin
    req_ready = rst_n && boot_done;
    wr_fire   = req_valid && req_ready;
    vec_hit   = in_window(32'(req_addr), VEC_BASE, VEC_TOP);
    dl_block  = req_download && vec_hit;
    if (fill_we) begin
      mem_we    = 1'b1;
      mem_addr  = fill_addr;
      mem_wdata = fill_data;
      mem_be    = 4'b1111;
    end else begin
      mem_we    = wr_fire && !dl_block;
      mem_addr  = req_addr;
      mem_wdata = req_wdata;
      mem_be    = req_be;
    end
  end

  resv_event_snoop #(
    .ADDR_W(ADDR_W), .N_CORES(N_CORES), .EVT_BASE(EVT_BASE)
  ) u_snoop (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(req_addr),
    .wr_be(req_be), .evt(core_event)
  );

  resv_exec_decode #(
    .ADDR_W(ADDR_W), .CORE_LIM(CORE_LIM), .TBL_LIM(TBL_LIM)
  ) u_exec (
    .fetch_addr(fetch_addr), .region(region)
  );

  assign exec_region = region;

  assert_boot_full_be_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !boot_done) |-> (mem_be == 4'b1111));

  assert_dl_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && req_valid && req_download &&
     (32'(req_addr) >= VEC_BASE)) |-> !mem_we);

  assert_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && req_valid && !req_download) |-> (mem_we && mem_addr == req_addr));

  assert_exec_core_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_region == 2'd0) |-> (32'(fetch_addr) < CORE_LIM));

endmodule

// File: tb/tb_shmem_resv_ctrl.sv
module tb_shmem_resv_ctrl;
  localparam logic [31:0] RET = 32'hFCB0_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [19:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_download = 1'b0;
  logic        req_ready, mem_we, boot_done;
  logic [19:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic [15:0] core_event;
  logic [19:0] fetch_addr = '0;
  logic [1:0]  exec_region;

  int n_chk = 0;
  int n_fail = 0;
  int boot_n = 0;
  logic [15:0] ev_exp = '0;
  int cycles = 0;

  always #10 clk = ~clk;

  shmem_resv_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_download(req_download),
    .req_ready(req_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .core_event(core_event),
    .boot_done(boot_done), .fetch_addr(fetch_addr), .exec_region(exec_region)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference, compared every cycle
  always @(negedge clk) begin
    int e;
    int a;
    a = int'(fetch_addr);
    e = (a < 'h200) ? 0 : (a < 'h400) ? 1 : 2;
    chk("R8", "exec_region", 32'(exec_region), e);
    if (!rst_n) begin
      boot_n = 0;
      ev_exp = '0;
      chk("R1", "mem_we", 32'(mem_we), 0);
      chk("R1", "core_event", 32'(core_event), 0);
      chk("R1", "req_ready", 32'(req_ready), 0);
      chk("R1", "boot_done", 32'(boot_done), 0);
    end else begin
      logic [15:0] nxt;
      chk("R6", "core_event", 32'(core_event), 32'(ev_exp));
      nxt = '0;
      if (boot_n < 16) begin
        chk("R3", "req_ready", 32'(req_ready), 0);
        chk("R3", "boot_done", 32'(boot_done), 0);
        chk("R2", "mem_we", 32'(mem_we), 1);
        chk("R2", "mem_addr", 32'(mem_addr), 32'h000FFFC0 + 4 * boot_n);
        chk("R2", "mem_wdata", mem_wdata, RET);
        chk("R2", "mem_be", 32'(mem_be), 32'hF);
        boot_n++;
      end else begin
        int ad;
        bit blk;
        ad = int'(req_addr);
        chk("R3", "req_ready", 32'(req_ready), 1);
        chk("R3", "boot_done", 32'(boot_done), 1);
        blk = req_download && (ad >= 'hFFFC0);
        chk(req_download ? "R5" : "R4", "mem_we", 32'(mem_we), 32'(req_valid && !blk));
        if (req_valid && !blk) begin
          chk("R4", "mem_addr", 32'(mem_addr), 32'(req_addr));
          chk("R4", "mem_wdata", mem_wdata, req_wdata);
          chk("R4", "mem_be", 32'(mem_be), 32'(req_be));
        end
        if (req_valid && req_be != 0 && ad >= 'hFFF80 && ad <= 'hFFFBF)
          nxt[(ad - 'hFFF80) / 4] = 1'b1;
      end
      ev_exp = nxt;
    end
  end

  task automatic put(input logic v, input logic [19:0] a, input logic [31:0] d,
                     input logic [3:0] be, input logic dl);
    @(posedge clk); #1;
    req_valid = v; req_addr = a; req_wdata = d; req_be = be; req_download = dl;
  endtask

  task automatic idle();
    put(1'b0, 20'h0, 32'h0, 4'h0, 1'b0);
  endtask

  task automatic fetch(input logic [19:0] a);
    @(posedge clk); #1;
    fetch_addr = a;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R3: requests during the fill are refused, including event-window hits
    for (int i = 0; i < 10; i++) put(1'b1, 20'hFFF80 + 20'(4 * (i % 16)), 32'hDEAD_0000 + i, 4'hF, 1'b0);
    repeat (10) idle();
    // R4: plain writes, including one to a vector long
    put(1'b1, 20'h01000, 32'h1111_2222, 4'hF, 1'b0);
    put(1'b1, 20'hFFFC4, 32'hAAAA_5555, 4'h3, 1'b0);
    // R5: download to vectors masked, elsewhere passes
    put(1'b1, 20'hFFFF8, 32'hBBBB_0000, 4'hF, 1'b1);
    put(1'b1, 20'hFFFC0, 32'hBBBB_0001, 4'hF, 1'b1);
    put(1'b1, 20'h02000, 32'hCCCC_0000, 4'hF, 1'b1);
    idle();
    // R6: each core, single byte lanes and offsets inside the long
    for (int n = 0; n < 16; n++)
      put(1'b1, 20'hFFF80 + 20'(4 * n + (n % 4)), 32'h0 + n, 4'(1 << (n % 4)), 1'b0);
    idle();
    // R7: zero byte enables, and neighbours outside the window
    put(1'b1, 20'hFFF84, 32'h0, 4'h0, 1'b0);
    put(1'b1, 20'hFFF7C, 32'h0, 4'hF, 1'b0);
    put(1'b1, 20'hFFFC0, 32'h0, 4'hF, 1'b0);
    // download write to an event long still pulses, same cycle as masking logic
    put(1'b1, 20'hFFFBC, 32'h0, 4'h8, 1'b1);
    put(1'b1, 20'hFFFFC, 32'h0, 4'hF, 1'b1);
    idle(); idle();
    // R8: region boundaries
    fetch(20'h00000); fetch(20'h001FF); fetch(20'h00200);
    fetch(20'h003FF); fetch(20'h00400); fetch(20'hFFFFF);
    // second reset re-runs the fill
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (18) idle();
    put(1'b1, 20'hFFF8C, 32'h5, 4'hF, 1'b0);
    put(1'b1, 20'hFFF90, 32'h6, 4'hF, 1'b0);
    idle(); idle(); idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule